// File: doc/BRIEF.md
# Serial Slave Byte Front End with Pause Control

This block sits between the four wires of a SPI memory slave and the command logic behind it. It brings the select, serial clock, serial data and pause pins into the system clock domain through synchronizer chains and finds the serial clock edges. It collects eight-bit bus cycles, most significant bit first, and hands each finished byte to the command logic with a one-cycle strobe and the position of the byte within the current selection. In the other direction, it shifts a response byte supplied by the command logic onto a serial output that has its own enable, so the pad can float.

The same logic serves both idle clock levels (mode 0 and mode 3). Data is captured on rising serial clock edges, and the output moves only after falling edges. A pause pin freezes the transfer without losing the bit position. The block enters and leaves the paused state only while the serial clock is low, and the output floats for the whole pause. If select rises in the middle of a byte, the partial byte is dropped and an abort strobe is raised.

Top module: `spi_slave_frontend`

## Requirements
- R1: After reset, `miso_oe`, `rx_valid` and `rx_abort` are low.
- R2: Eight rising serial clock edges while active assemble one byte, first bit in bit 7. It is presented on `rx_byte` together with a `rx_valid` pulse one system clock wide.
- R3: `rx_index` carries the position of the presented byte within the current selection. The first byte after a select falling edge has index 0, and each later byte adds one.
- R4: Transfers work the same whether the serial clock idles low (mode 0) or high (mode 3) while select is high.
- R5: The first response bit is bit 7 of `tx_byte`, captured when select falls. The output moves to the next bit only after a falling serial clock edge that follows a rising edge of the same byte. The next `tx_byte` is captured at the first falling edge after a byte completes.
- R6: A select rise after one to seven bits of a byte gives one `rx_abort` pulse and no `rx_valid`. The partial bits are discarded, so the next selection starts from an empty byte at index 0. A select rise exactly on a byte boundary gives no abort.
- R7: The pause state is entered only while select is low. A pause pin fall while the serial clock is high takes effect only at the next serial clock low level.
- R8: While paused, `miso_oe` is low, and serial clock and data activity change neither the received bits nor the response bit position.
- R9: A pause pin rise while the serial clock is high leaves the block paused until the serial clock is next low.
- R10: A select rise during a pause returns the block to standby and aborts the partial byte. After select falls again with the pause pin still low, the block stays paused until the pause pin rises.
- R11: `miso_oe` is high only while select is low, the block is not paused, and `tx_drive` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data into the slave |
| hold_n | input | 1 | Pause request, active low |
| tx_byte | input | DATA_W | Response byte from the command logic |
| tx_drive | input | 1 | Command logic asks for the output to be driven |
| rx_byte | output | DATA_W | Last completed received byte |
| rx_valid | output | 1 | One-cycle strobe for a completed byte |
| rx_index | output | IDX_W | Position of the presented byte in the selection |
| rx_abort | output | 1 | One-cycle strobe for a byte cut off by a select rise |
| miso | output | 1 | Serial response data |
| miso_oe | output | 1 | Output enable for the serial response pad |

## Verification
The hardest case to reach is a pause that begins and ends while the serial clock is high, with the clock toggling during the pause, in the middle of a byte. Directed stimulus drops the pause pin after a rising edge and checks that the output is still enabled. It then lowers the clock, toggles clock and data while paused, and raises the pause pin with the clock high. The byte is then finished, and the bench checks that both the received byte and the shifted response are the same as in a transfer without a pause. A second directed case ends a selection during a pause and reselects with the pause pin still low. Randomized multi-byte transfers in both clock modes cover the byte strobes, the indices and the response loading.

// File: rtl/spi_fe_pkg.sv
// Shared types for the serial front end: synchronized pin levels and
// detected edges. Assumes the four serial pins are sampled together.
package spi_fe_pkg;
    typedef struct packed {
        logic cs_n;
        logic sck;
        logic mosi;
        logic hold_n;
    } pins_t;

    typedef struct packed {
        logic sck_rise;
        logic sck_fall;
        logic cs_fall;
        logic cs_rise;
    } edges_t;

    // Idle pin state: deselected, clock low, no pause.
    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, mosi: 1'b0, hold_n: 1'b1};
endpackage

// File: rtl/spi_fe_sync.sv
// Brings the asynchronous serial pins into the system clock domain through
// a STAGES-deep flop chain and derives single-cycle edge flags.
// Assumes the serial clock half period exceeds STAGES + 2 system clocks.
module spi_fe_sync
    import spi_fe_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  pins_t  raw,
    output pins_t  lvl,
    output edges_t edg
);
    pins_t chain [STAGES];
    pins_t prev;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the pins directly.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= PINS_IDLE;
                else        chain[g] <= raw;
            end
        end else begin : g_next
            // Later stages settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= PINS_IDLE;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign lvl = chain[STAGES-1];

    // Previous level, kept for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= PINS_IDLE;
        else        prev <= lvl;
    end

    // Edge flags from the current and previous synchronized levels.
    always_comb begin
        edg.sck_rise = lvl.sck & ~prev.sck;
        edg.sck_fall = ~lvl.sck & prev.sck;
        edg.cs_fall  = ~lvl.cs_n & prev.cs_n;
        edg.cs_rise  = lvl.cs_n & ~prev.cs_n;
    end
endmodule

// File: rtl/spi_fe_hold.sv
// Tracks the paused state. The state changes only while the serial clock is
// low, and a deselect clears it. Assumes synchronized inputs.
module spi_fe_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    output logic held
);
    // Follow the pause pin only at serial clock low; standby when deselected.
    always_ff @(posedge clk) begin
        if (!rst_n)    held <= 1'b0;
        else if (cs_n) held <= 1'b0;
        else if (!sck) held <= ~hold_n;
    end

    a_r7_entry_at_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> $past(!sck && !cs_n));

    a_r9_exit_at_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(held) |-> $past(!sck || cs_n));
endmodule

// File: rtl/spi_fe_shift.sv
// Byte engine: shifts receive bits in on rising serial clock edges and the
// response out after falling edges. Tracks bit and byte positions and flags
// a byte cut off by deselect. Assumes edge flags are one cycle wide.
module spi_fe_shift
    import spi_fe_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  edges_t            edg,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic              held,
    input  logic [DATA_W-1:0] tx_byte,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic [IDX_W-1:0]  rx_index,
    output logic              rx_abort,
    output logic              miso
);
    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [IDX_W-1:0]  byte_cnt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic              reload_pend;
    logic              active;

    assign active = ~cs_n & ~held;
    assign miso   = tx_sh[DATA_W-1];

    // Bit capture, byte hand-off, response shifting and abort detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt     <= '0;
            byte_cnt    <= '0;
            rx_sh       <= '0;
            tx_sh       <= '0;
            rx_byte     <= '0;
            rx_index    <= '0;
            rx_valid    <= 1'b0;
            rx_abort    <= 1'b0;
            reload_pend <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            rx_abort <= 1'b0;
            if (edg.cs_fall) begin
                bit_cnt     <= '0;
                byte_cnt    <= '0;
                tx_sh       <= tx_byte;
                reload_pend <= 1'b0;
            end else if (edg.cs_rise) begin
                rx_abort    <= (bit_cnt != '0);
                bit_cnt     <= '0;
                reload_pend <= 1'b0;
            end else if (active && edg.sck_rise) begin
                rx_sh <= {rx_sh[DATA_W-2:0], mosi};
                if (bit_cnt == LAST_BIT) begin
                    rx_byte     <= {rx_sh[DATA_W-2:0], mosi};
                    rx_valid    <= 1'b1;
                    rx_index    <= byte_cnt;
                    byte_cnt    <= byte_cnt + 1'b1;
                    bit_cnt     <= '0;
                    reload_pend <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end else if (active && edg.sck_fall) begin
                if (reload_pend) begin
                    tx_sh       <= tx_byte;
                    reload_pend <= 1'b0;
                end else if (bit_cnt != '0) begin
                    tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r6_abort_not_byte: assert property (@(posedge clk) disable iff (!rst_n)
        rx_abort |-> !rx_valid);

    a_r8_pause_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !edg.cs_rise) |=> ($stable(bit_cnt) && $stable(tx_sh)));
endmodule

// File: rtl/spi_slave_frontend.sv
// Top of the serial front end: synchronizer, pause tracker and byte engine.
// Assumes the system clock runs well above the serial clock.
module spi_slave_frontend
    import spi_fe_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int IDX_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    input  logic              hold_n,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tx_drive,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic [IDX_W-1:0]  rx_index,
    output logic              rx_abort,
    output logic              miso,
    output logic              miso_oe
);
    pins_t  raw_pins;
    pins_t  lvl;
    edges_t edg;
    logic   held;

    assign raw_pins = '{cs_n: cs_n, sck: sck, mosi: mosi, hold_n: hold_n};

    spi_fe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(raw_pins), .lvl(lvl), .edg(edg)
    );

    spi_fe_hold u_hold (
        .clk(clk), .rst_n(rst_n), .cs_n(lvl.cs_n), .sck(lvl.sck),
        .hold_n(lvl.hold_n), .held(held)
    );

    spi_fe_shift #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .edg(edg), .cs_n(lvl.cs_n), .mosi(lvl.mosi),
        .held(held), .tx_byte(tx_byte), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .rx_index(rx_index), .rx_abort(rx_abort), .miso(miso)
    );

    // Drive the pad only when selected, not paused, and requested.
    assign miso_oe = ~lvl.cs_n & ~held & tx_drive;

    a_r5_miso_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!edg.sck_fall && !edg.cs_fall) |=> $stable(miso));
endmodule

// File: tb/spi_slave_frontend_tb.sv
module spi_slave_frontend_tb;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_drive = 1'b1;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic [7:0] rx_index;
    logic       rx_abort, miso, miso_oe;

    int n_tests = 0, n_fail = 0;
    int n_rx = 0, n_abort = 0;
    logic [7:0] last_rx, last_idx;
    logic [7:0] txd [4];
    logic [7:0] rxd [4];
    logic [7:0] got;
    logic       bit_got;
    int         rx_before, ab_before;

    always #10 clk = ~clk;

    spi_slave_frontend u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .hold_n(hold_n), .tx_byte(tx_byte), .tx_drive(tx_drive),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_index(rx_index),
        .rx_abort(rx_abort), .miso(miso), .miso_oe(miso_oe)
    );

    // Record strobes seen at the ports.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            last_rx  = rx_byte;
            last_idx = rx_index;
            n_rx++;
        end
        if (rst_n && rx_abort) n_abort++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_h();
        repeat (H) @(negedge clk);
    endtask

    task automatic start(input logic mode3);
        sck = mode3;
        wait_h();
        cs_n = 1'b0;
        wait_h();
    endtask

    task automatic finish_sel(input logic mode3);
        if (!mode3) sck = 1'b0;
        wait_h();
        cs_n = 1'b1;
        wait_h();
    endtask

    // One serial bit: fall, present data, sample response, rise.
    task automatic bit_io(input logic b, output logic r);
        sck  = 1'b0;
        mosi = b;
        wait_h();
        r    = miso;
        sck  = 1'b1;
        wait_h();
    endtask

    task automatic xfer(input logic mode3, input int nb);
        tx_byte = txd[0];
        start(mode3);
        check("R11 oe while selected", miso_oe, 1'b1);
        for (int k = 0; k < nb; k++) begin
            rx_before = n_rx;
            for (int i = 7; i >= 0; i--) begin
                bit_io(rxd[k][i], bit_got);
                got[i] = bit_got;
            end
            if (k + 1 < nb) tx_byte = txd[k+1];
            check(mode3 ? "R4 R5 response mode3" : "R4 R5 response mode0", got, txd[k]);
            check("R2 one strobe per byte", n_rx - rx_before, 1);
            check(mode3 ? "R2 R4 rx byte mode3" : "R2 R4 rx byte mode0", last_rx, rxd[k]);
            check("R3 byte index", last_idx, k);
        end
        ab_before = n_abort;
        finish_sel(mode3);
        check("R6 no abort at boundary", n_abort - ab_before, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 oe after reset", miso_oe, 1'b0);
        check("R1 valid after reset", rx_valid, 1'b0);
        check("R1 abort after reset", rx_abort, 1'b0);

        // Directed multi-byte transfers in both modes.
        txd = '{8'hA5, 8'h3C, 8'h81, 8'h7E};
        rxd = '{8'h96, 8'h01, 8'hFF, 8'h80};
        xfer(1'b0, 4);
        xfer(1'b1, 4);

        // Randomized transfers.
        for (int t = 0; t < 8; t++) begin
            int nb;
            logic m3;
            nb = 1 + int'($urandom_range(3));
            m3 = 1'($urandom_range(1));
            for (int k = 0; k < 4; k++) begin
                txd[k] = 8'($urandom);
                rxd[k] = 8'($urandom);
            end
            xfer(m3, nb);
        end

        // R6: select rise after five bits.
        tx_byte = 8'hFF;
        start(1'b0);
        rx_before = n_rx; ab_before = n_abort;
        for (int i = 0; i < 5; i++) bit_io(1'b1, bit_got);
        cs_n = 1'b1;
        wait_h();
        check("R6 abort pulse", n_abort - ab_before, 1);
        check("R6 no strobe on abort", n_rx - rx_before, 0);
        txd[0] = 8'h12; rxd[0] = 8'h0F;
        xfer(1'b0, 1);

        // R7 R8 R9: pause entered and left with the clock high, mid-byte.
        txd[0] = 8'hA5; rxd[0] = 8'h3C;
        tx_byte = txd[0];
        start(1'b0);
        rx_before = n_rx;
        for (int i = 7; i >= 4; i--) begin
            bit_io(rxd[0][i], bit_got);
            got[i] = bit_got;
        end
        hold_n = 1'b0;
        wait_h();
        check("R7 entry deferred while clock high", miso_oe, 1'b1);
        sck = 1'b0;
        wait_h();
        check("R8 output floats in pause", miso_oe, 1'b0);
        for (int j = 0; j < 3; j++) begin
            mosi = ~mosi;
            sck = 1'b1; wait_h();
            sck = 1'b0; wait_h();
        end
        sck = 1'b1;
        wait_h();
        hold_n = 1'b1;
        wait_h();
        check("R9 exit deferred while clock high", miso_oe, 1'b0);
        check("R8 no byte during pause", n_rx - rx_before, 0);
        for (int i = 3; i >= 0; i--) begin
            bit_io(rxd[0][i], bit_got);
            got[i] = bit_got;
        end
        check("R9 output back after exit", miso_oe, 1'b1);
        check("R8 rx byte across pause", last_rx, rxd[0]);
        check("R8 response across pause", got, txd[0]);
        check("R8 single strobe", n_rx - rx_before, 1);
        finish_sel(1'b0);

        // R10: deselect during pause, reselect with pause still low.
        tx_byte = 8'h5A;
        start(1'b0);
        bit_io(1'b1, bit_got);
        bit_io(1'b0, bit_got);
        sck = 1'b0;
        hold_n = 1'b0;
        wait_h();
        check("R10 paused", miso_oe, 1'b0);
        ab_before = n_abort;
        cs_n = 1'b1;
        wait_h();
        check("R10 abort on deselect in pause", n_abort - ab_before, 1);
        txd[0] = 8'hC3; rxd[0] = 8'h6D;
        tx_byte = txd[0];
        cs_n = 1'b0;
        wait_h();
        check("R10 still paused after reselect", miso_oe, 1'b0);
        hold_n = 1'b1;
        wait_h();
        check("R10 resumes when pause pin high", miso_oe, 1'b1);
        for (int i = 7; i >= 0; i--) begin
            bit_io(rxd[0][i], bit_got);
            got[i] = bit_got;
        end
        check("R10 byte after resume", last_rx, rxd[0]);
        check("R10 index restarts", last_idx, 0);
        check("R10 response after resume", got, txd[0]);
        finish_sel(1'b0);

        // R11: drive request and deselect gate the enable.
        tx_byte = 8'h00;
        start(1'b0);
        tx_drive = 1'b0;
        wait_h();
        check("R11 no drive request", miso_oe, 1'b0);
        tx_drive = 1'b1;
        wait_h();
        check("R11 drive request", miso_oe, 1'b1);
        cs_n = 1'b1;
        wait_h();
        check("R11 deselected", miso_oe, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule